// File: doc/BRIEF.md
# Byte Flag-Updating Shift and Step Unit

This block is one execution slot for 8-bit operands. On each clock edge it takes an opcode, an operand, a shift count and the current flag vector. One clock later it presents the result and the next flag vector. The operations are increment, decrement, ones' complement, a left shift by a count and an arithmetic right shift by a count.

Each operation writes only the flags it owns and carries every other flag bit through unchanged. This lets the surrounding datapath feed the flag output straight back into the flag input with no masking. Three cases need attention. Decrement never touches carry. After a multi-bit shift, carry holds the last bit that fell off the operand. A zero shift count is a complete no-op.

Encodings used throughout:
- Opcodes: 0 increment, 1 decrement, 2 complement, 3 left shift, 4 arithmetic right shift, 5 to 7 reserved.
- Flag vector: bit 0 carry (C), bit 1 parity (P), bit 2 zero (Z), bit 3 sign (S), bit 4 overflow (O).

Top module: `bfu_top`

## Requirements
- R1: Outputs are registered. The result and flags for inputs sampled at a rising edge appear after that edge. While `rst` is high, `result_o` and `flags_o` read zero.
- R2: Increment (opcode 0) gives operand+1 modulo 256. C is set only for operand FFh. O is set only for operand 7Fh.
- R3: Decrement (opcode 1) gives operand-1 modulo 256 and keeps C exactly as supplied. O is set only for operand 80h.
- R4: Complement (opcode 2) gives the bitwise inverse of the operand and returns all five flag bits unchanged.
- R5: Left shift (opcode 3) by n in 1..7 fills vacated low bits with zeros. C takes the last bit shifted out, which is operand bit 8-n. For example, 23h by 2 gives 8Ch with C=0.
- R6: Arithmetic right shift (opcode 4) by n in 1..7 copies the sign bit into vacated high bits. C takes operand bit n-1. For example, 80h by 3 gives F0h.
- R7: For increment, decrement and any shift with nonzero count, the flags follow the result. Z is set only when the result is zero. S equals result bit 7. P is set when the result has an even number of ones.
- R8: A left shift by 1 sets O to S xor C of the new value. An arithmetic right shift by 1 clears O. Shifts by 2 or more keep O as supplied.
- R9: A shift with count 0 returns the operand and all flags unchanged.
- R10: Reserved opcodes 5 to 7 return the operand and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select |
| operand_i | input | 8 | Byte operand |
| count_i | input | 3 | Shift count for opcodes 3 and 4 |
| flags_i | input | 5 | Current flag vector {O,S,Z,P,C} |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered next flag vector |

## Verification
Every result and flag bit is due exactly one rising edge after its inputs were sampled. The bench drives each input set on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. Each vector is therefore checked after exactly one register stage, with no sensitivity to the order of processes at the edge. The reset check reads the outputs at a falling edge while reset is still high, after the first reset edge.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int FLAG_W = 5;
    localparam int FL_C   = 0;
    localparam int FL_P   = 1;
    localparam int FL_Z   = 2;
    localparam int FL_S   = 3;
    localparam int FL_O   = 4;

    typedef enum logic [2:0] {
        OP_INC = 3'd0,
        OP_DEC = 3'd1,
        OP_NOT = 3'd2,
        OP_SHL = 3'd3,
        OP_SAR = 3'd4
    } bfu_op_e;

endpackage

// File: rtl/bfu_step_core.sv
module bfu_step_core
    import bfu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      res_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;

    always_comb begin
        sum     = {1'b0, a_i} + {{W{1'b0}}, 1'b1};
        res_o   = a_i;
        flags_o = flags_i;
        case (op_i)
            OP_INC: begin
                res_o         = sum[W-1:0];
                flags_o[FL_C] = sum[W];
                flags_o[FL_O] = (a_i == MAX_POS);
            end
            OP_DEC: begin
                res_o         = a_i - {{(W-1){1'b0}}, 1'b1};
                flags_o[FL_O] = (a_i == MIN_NEG);
            end
            OP_NOT: res_o = ~a_i;
            default: res_o = a_i;
        endcase
        if (op_i == OP_INC || op_i == OP_DEC) begin
            flags_o[FL_Z] = (res_o == '0);
            flags_o[FL_S] = res_o[W-1];
            flags_o[FL_P] = ~^res_o;
        end
    end

endmodule

// File: rtl/bfu_shift_core.sv
module bfu_shift_core
    import bfu_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic [2:0]        op_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [W-1:0]      a_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      res_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [W:0]        left_ext;
    logic signed [W:0] right_ext;
    logic              active;

    always_comb begin
        left_ext  = {1'b0, a_i} << cnt_i;
        right_ext = $signed({a_i, 1'b0}) >>> cnt_i;
        active    = (cnt_i != '0) && (op_i == OP_SHL || op_i == OP_SAR);
        res_o     = a_i;
        flags_o   = flags_i;
        if (active) begin
            if (op_i == OP_SHL) begin
                res_o         = left_ext[W-1:0];
                flags_o[FL_C] = left_ext[W];
                if (cnt_i == ONE)
                    flags_o[FL_O] = left_ext[W-1] ^ left_ext[W];
            end else begin
                res_o         = right_ext[W:1];
                flags_o[FL_C] = right_ext[0];
                if (cnt_i == ONE)
                    flags_o[FL_O] = 1'b0;
            end
            flags_o[FL_Z] = (res_o == '0);
            flags_o[FL_S] = res_o[W-1];
            flags_o[FL_P] = ~^res_o;
        end
    end

endmodule

// File: rtl/bfu_top.sv
module bfu_top
    import bfu_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [W-1:0]      operand_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [W-1:0]      step_res,   shift_res,   next_res;
    logic [FLAG_W-1:0] step_flags, shift_flags, next_flags;

    bfu_step_core #(.W(W)) u_step (
        .op_i    (op_i),
        .a_i     (operand_i),
        .flags_i (flags_i),
        .res_o   (step_res),
        .flags_o (step_flags)
    );

    bfu_shift_core #(.W(W), .CNT_W(CNT_W)) u_shift (
        .op_i    (op_i),
        .cnt_i   (count_i),
        .a_i     (operand_i),
        .flags_i (flags_i),
        .res_o   (shift_res),
        .flags_o (shift_flags)
    );

    always_comb begin
        case (op_i)
            OP_INC, OP_DEC, OP_NOT: begin
                next_res   = step_res;
                next_flags = step_flags;
            end
            OP_SHL, OP_SAR: begin
                next_res   = shift_res;
                next_flags = shift_flags;
            end
            default: begin
                next_res   = operand_i;
                next_flags = flags_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            flags_o  <= '0;
        end else begin
            result_o <= next_res;
            flags_o  <= next_flags;
        end
    end

    // R3: decrement keeps carry
    p_dec_keeps_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DEC) |=> (flags_o[FL_C] == $past(flags_i[FL_C])));

    // R4: complement inverts operand, flags pass through
    p_not_passes_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOT) |=> (result_o == ~$past(operand_i)) && (flags_o == $past(flags_i)));

    // R2: increment carry only on wrap
    p_inc_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC) |=> (flags_o[FL_C] == ($past(operand_i) == {W{1'b1}})));

    // R7: zero and sign follow the registered result
    p_zero_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC || op_i == OP_DEC) |=>
            (flags_o[FL_Z] == (result_o == '0)) && (flags_o[FL_S] == result_o[W-1]));

    // R9: zero-count shift is a no-op
    p_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_SHL || op_i == OP_SAR) && count_i == '0) |=>
            (result_o == $past(operand_i)) && (flags_o == $past(flags_i)));

    // R8: single-bit arithmetic right shift clears overflow
    p_sar1_clears_of_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SAR && count_i == {{(CNT_W-1){1'b0}}, 1'b1}) |=> !flags_o[FL_O]);

endmodule

// File: tb/bfu_top_tb.sv
module bfu_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_i = '0;
    logic [7:0] operand_i = '0;
    logic [2:0] count_i = '0;
    logic [4:0] flags_i = '0;
    logic [7:0] result_o;
    logic [4:0] flags_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bfu_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .operand_i (operand_i),
        .count_i   (count_i),
        .flags_i   (flags_i),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    // {op, count, operand, flags_in, exp_result, exp_flags}; flags = {O,S,Z,P,C}
    localparam int NV = 16;
    localparam logic [31:0] VEC [NV] = '{
        {3'd1, 3'd0, 8'h00, 5'h01, 8'hFF, 5'h0B},  // R3 R7: dec 00 -> FF, C kept
        {3'd0, 3'd0, 8'h7F, 5'h00, 8'h80, 5'h18},  // R2: overflow on 7F
        {3'd0, 3'd0, 8'hFF, 5'h00, 8'h00, 5'h07},  // R2 R7: wrap sets C, Z
        {3'd1, 3'd0, 8'h80, 5'h00, 8'h7F, 5'h10},  // R3: overflow on 80
        {3'd2, 3'd0, 8'hC3, 5'h15, 8'h3C, 5'h15},  // R4
        {3'd3, 3'd2, 8'h23, 5'h1F, 8'h8C, 5'h18},  // R5 R8: O kept for n=2
        {3'd4, 3'd3, 8'h80, 5'h00, 8'hF0, 5'h0A},  // R6
        {3'd3, 3'd1, 8'hC0, 5'h00, 8'h80, 5'h09},  // R8: O = S^C = 0
        {3'd3, 3'd1, 8'h40, 5'h00, 8'h80, 5'h18},  // R8: O = 1
        {3'd4, 3'd1, 8'h05, 5'h10, 8'h02, 5'h01},  // R6 R8: O cleared, C=1
        {3'd3, 3'd7, 8'h03, 5'h00, 8'h80, 5'h09},  // R5: C = bit 1
        {3'd4, 3'd0, 8'h5A, 5'h13, 8'h5A, 5'h13},  // R9
        {3'd3, 3'd0, 8'hA5, 5'h0C, 8'hA5, 5'h0C},  // R9
        {3'd6, 3'd2, 8'h3C, 5'h1E, 8'h3C, 5'h1E},  // R10
        {3'd4, 3'd7, 8'h7F, 5'h00, 8'h00, 5'h07},  // R6 R7: C = bit 6, Z
        {3'd1, 3'd0, 8'h01, 5'h00, 8'h00, 5'h06}   // R3 R7: Z, P, C stays 0
    };

    task automatic check(input string req, input logic [7:0] er, input logic [4:0] ef);
        checks++;
        if (result_o !== er || flags_o !== ef) begin
            errors++;
            $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                     req, result_o, flags_o, er, ef);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [2:0] cnt,
                         input logic [7:0] a, input logic [4:0] fl);
        @(negedge clk);
        op_i = op; count_i = cnt; operand_i = a; flags_i = fl;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: result=%h flags=%h expected completion", result_o, flags_o);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with non-trivial inputs present
        op_i = 3'd0; operand_i = 8'hFF; flags_i = 5'h1F;
        repeat (2) @(negedge clk);
        check("R1 reset", 8'h00, 5'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][31:29], VEC[i][28:26], VEC[i][25:18], VEC[i][17:13]);
            check($sformatf("vector %0d", i), VEC[i][12:5], VEC[i][4:0]);
        end

        // R10: remaining reserved codes
        apply(3'd5, 3'd1, 8'h81, 5'h0F);
        check("R10 op5", 8'h81, 5'h0F);
        apply(3'd7, 3'd3, 8'h00, 5'h10);
        check("R10 op7", 8'h00, 5'h10);

        // R5 R8: left shift by 1 of 80h -> 00, C=1, O = 0^1
        apply(3'd3, 3'd1, 8'h80, 5'h00);
        check("R5 R8 shl1 80", 8'h00, 5'h17);

        // R1: output holds the previous value until the capturing edge
        @(negedge clk);
        op_i = 3'd2; operand_i = 8'h0F; flags_i = 5'h00;
        #5;
        check("R1 latency hold", 8'h00, 5'h17);
        @(negedge clk);
        check("R1 latency update", 8'hF0, 5'h00);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", 8'h00, 5'h00);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule